// File: doc/BRIEF.md
# Context-Banked Carry and Zero Flags

This block holds the carry and zero condition flags of a small processor core as three private pairs, one for each execution context: the main program, maskable interrupt service and non-maskable interrupt service. The context that is active at any moment decides which pair the flag-update strobes write and which pair appears on the flag outputs. The block never saves, copies or clears a pair when the context changes. A service routine therefore gets its own flags for free, and the interrupted code finds its flags untouched when it resumes.

The context follows three strobes from the core. One means that an interrupt was accepted, one means that a non-maskable interrupt was accepted, and one marks a return-from-interrupt instruction. A two-entry return record remembers which context was interrupted. This lets the nesting main → interrupt → non-maskable unwind one level per return. Out of reset the non-maskable context is active, so start-up code runs on that pair. A return issued with an empty record drops back to the main context.

Top module: `ctx_flag_bank`

## Requirements
- R1: After reset, `mode_o` is 2 (non-maskable context), and `carry_o` and `zero_o` are 0. The mode codes are 0 for main, 1 for interrupt and 2 for non-maskable.
- R2: When `carry_we` is high and `carry_from_bit` is low, the active pair's carry takes `alu_carry` at the clock edge. The new value shows on `carry_o` after that edge.
- R3: When `carry_we` is high and `carry_from_bit` is high, the active pair's carry takes `bit_val` instead of `alu_carry`.
- R4: When `zero_we` is high, the active pair's zero flag takes `alu_zero` at the clock edge.
- R5: `irq_take` moves the mode from 0 to 1 at the next edge. It is ignored in modes 1 and 2.
- R6: `nmi_take` moves the mode from 0 or 1 to 2 at the next edge, and the mode it left is recorded. It is ignored in mode 2.
- R7: `reti` in mode 1 or 2 restores the most recently recorded mode. With an empty record it goes to mode 0. After 0→1→2, two returns give 1 and then 0.
- R8: `reti` in mode 0 leaves the mode and the flags unchanged.
- R9: A pair that is not active keeps its values across any number of context switches. When its context returns, the outputs show exactly what that pair held before.
- R10: A flag write in the same cycle as a context change goes to the pair of the context that was active before the edge.
- R11: When strobes coincide, an acting `nmi_take` wins over `reti`, and an asserted `reti` blocks `irq_take` in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| alu_carry | input | 1 | Carry/borrow out of the arithmetic unit |
| alu_zero | input | 1 | High when the ALU result is zero |
| bit_val | input | 1 | Value of the bit examined by a bit-test |
| carry_we | input | 1 | Write the active carry flag |
| carry_from_bit | input | 1 | Carry source select: 1 takes bit_val, 0 takes alu_carry |
| zero_we | input | 1 | Write the active zero flag |
| irq_take | input | 1 | Maskable interrupt accepted this cycle |
| nmi_take | input | 1 | Non-maskable interrupt accepted this cycle |
| reti | input | 1 | Return-from-interrupt executed this cycle |
| carry_o | output | 1 | Carry flag of the active context |
| zero_o | output | 1 | Zero flag of the active context |
| mode_o | output | 2 | Active context: 0 main, 1 interrupt, 2 non-maskable |

## Verification
The assertions assume that each strobe is a single-cycle pulse sampled at a rising edge, and that the inputs are free of X after reset. They also assume the write strobes are valid even in a cycle that switches context. Some cycles of the stimulus raise `irq_take`, `nmi_take` and `reti` together or raise a strobe in a mode that must ignore it. These cycles exercise the priority and ignore rules. All inputs are driven on the falling edge, so each one is stable for a full half period before the edge that samples it. The randomized phase keeps strobe rates low, so nesting reaches full depth and also unwinds from it.

// File: rtl/ctxflag_pkg.sv
package ctxflag_pkg;
    localparam int NUM_CTX   = 3;
    localparam int RET_DEPTH = 2;
    localparam int MODE_W    = 2;

    typedef enum logic [MODE_W-1:0] {
        CTX_NORM = 2'd0,
        CTX_IRQ  = 2'd1,
        CTX_NMI  = 2'd2
    } ctx_e;

    typedef struct packed {
        logic c;
        logic z;
    } flags_t;
endpackage

// File: rtl/ctx_tracker.sv
module ctx_tracker
    import ctxflag_pkg::*;
#(
    parameter int DEPTH = RET_DEPTH
) (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_take,
    input  logic nmi_take,
    input  logic reti,
    output ctx_e mode_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [MODE_W-1:0]            mode;
        logic [DEPTH-1:0][MODE_W-1:0] rec;
        logic [CW-1:0]                cnt;
    } trk_t;

    trk_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (nmi_take && s_q.mode != CTX_NMI) begin
            // enter non-maskable service, remember interrupted context
            if (s_q.cnt < CW'(DEPTH)) begin
                s_d.rec[IW'(s_q.cnt)] = s_q.mode;
                s_d.cnt               = s_q.cnt + 1'b1;
            end
            s_d.mode = CTX_NMI;
        end else if (reti) begin
            if (s_q.mode != CTX_NORM) begin
                if (s_q.cnt == '0) begin
                    s_d.mode = CTX_NORM;
                end else begin
                    s_d.mode = s_q.rec[IW'(s_q.cnt - 1'b1)];
                    s_d.cnt  = s_q.cnt - 1'b1;
                end
            end
        end else if (irq_take && s_q.mode == CTX_NORM) begin
            s_d.rec[IW'(s_q.cnt)] = s_q.mode;
            s_d.cnt               = s_q.cnt + 1'b1;
            s_d.mode              = CTX_IRQ;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mode <= CTX_NMI;
            s_q.rec  <= '0;
            s_q.cnt  <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode_o = ctx_e'(s_q.mode);

    a_r5_irq_from_norm: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == CTX_NORM && irq_take && !nmi_take && !reti) |=> mode_o == CTX_IRQ);

    a_r5_irq_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o != CTX_NORM && !nmi_take && !reti) |=> mode_o == $past(mode_o));

    a_r6_nmi_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_take && mode_o != CTX_NMI) |=> mode_o == CTX_NMI);

    a_r8_reti_in_norm: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == CTX_NORM && reti && !nmi_take) |=> mode_o == CTX_NORM);

    a_r11_nmi_beats_reti: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == CTX_IRQ && reti && nmi_take) |=> mode_o == CTX_NMI);

    a_r7_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(DEPTH));
endmodule

// File: rtl/flag_pair.sv
module flag_pair
    import ctxflag_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic c_we,
    input  logic c_val,
    input  logic z_we,
    input  logic z_val,
    output logic c_o,
    output logic z_o
);
    flags_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (c_we) f_d.c = c_val;
        if (z_we) f_d.z = z_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign c_o = f_q.c;
    assign z_o = f_q.z;

    a_r2_carry_load: assert property (@(posedge clk) disable iff (!rst_n)
        c_we |=> c_o == $past(c_val));

    a_r4_zero_load: assert property (@(posedge clk) disable iff (!rst_n)
        z_we |=> z_o == $past(z_val));

    a_r9_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!c_we && !z_we) |=> ($stable(c_o) && $stable(z_o)));
endmodule

// File: rtl/ctx_flag_bank.sv
module ctx_flag_bank
    import ctxflag_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       alu_carry,
    input  logic       alu_zero,
    input  logic       bit_val,
    input  logic       carry_we,
    input  logic       carry_from_bit,
    input  logic       zero_we,
    input  logic       irq_take,
    input  logic       nmi_take,
    input  logic       reti,
    output logic       carry_o,
    output logic       zero_o,
    output logic [1:0] mode_o
);
    ctx_e               mode;
    logic [MODE_W-1:0]  mode_w;
    logic               carry_src;
    logic [NUM_CTX-1:0] c_we_vec, z_we_vec, c_vec, z_vec;

    ctx_tracker #(.DEPTH(RET_DEPTH)) u_trk (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_take (irq_take),
        .nmi_take (nmi_take),
        .reti     (reti),
        .mode_o   (mode)
    );

    assign mode_w    = mode;
    assign carry_src = carry_from_bit ? bit_val : alu_carry;

    for (genvar k = 0; k < NUM_CTX; k++) begin : g_bank
        assign c_we_vec[k] = carry_we && (mode_w == MODE_W'(k));
        assign z_we_vec[k] = zero_we  && (mode_w == MODE_W'(k));

        flag_pair u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .c_we  (c_we_vec[k]),
            .c_val (carry_src),
            .z_we  (z_we_vec[k]),
            .z_val (alu_zero),
            .c_o   (c_vec[k]),
            .z_o   (z_vec[k])
        );
    end

    always_comb begin
        carry_o = 1'b0;
        zero_o  = 1'b0;
        for (int k = 0; k < NUM_CTX; k++) begin
            if (mode_w == MODE_W'(k)) begin
                carry_o = c_vec[k];
                zero_o  = z_vec[k];
            end
        end
    end

    assign mode_o = mode_w;

    a_r10_one_bank_written: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(c_we_vec) && $onehot0(z_we_vec));

    a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
        mode_o != 2'd3);
endmodule

// File: tb/ctx_flag_bank_test.sv
module ctx_flag_bank_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic alu_carry = 0, alu_zero = 0, bit_val = 0;
    logic carry_we = 0, carry_from_bit = 0, zero_we = 0;
    logic irq_take = 0, nmi_take = 0, reti = 0;
    logic carry_o, zero_o;
    logic [1:0] mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model state
    int m_mode;
    int m_cnt;
    int m_stk [2];
    bit m_c [3];
    bit m_z [3];

    logic [3:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    ctx_flag_bank uut (
        .clk(clk), .rst_n(rst_n),
        .alu_carry(alu_carry), .alu_zero(alu_zero), .bit_val(bit_val),
        .carry_we(carry_we), .carry_from_bit(carry_from_bit), .zero_we(zero_we),
        .irq_take(irq_take), .nmi_take(nmi_take), .reti(reti),
        .carry_o(carry_o), .zero_o(zero_o), .mode_o(mode_o)
    );

    task automatic compare(input logic [3:0] exp, input string tag);
        logic [3:0] act;
        act = {carry_o, zero_o, mode_o};
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got c=%b z=%b mode=%0d, expected c=%b z=%b mode=%0d",
                     tag, act[3], act[2], act[1:0], exp[3], exp[2], exp[1:0]);
        end
    endtask

    // driver: applies one cycle of stimulus and pushes the expected result
    task automatic step(input bit ac, input bit az, input bit bv,
                        input bit cwe, input bit csel, input bit zwe,
                        input bit irq, input bit nmi, input bit rt,
                        input string tag);
        int cur;
        @(negedge clk);
        alu_carry = ac; alu_zero = az; bit_val = bv;
        carry_we = cwe; carry_from_bit = csel; zero_we = zwe;
        irq_take = irq; nmi_take = nmi; reti = rt;
        cur = m_mode;
        if (cwe) m_c[cur] = csel ? bv : ac;
        if (zwe) m_z[cur] = az;
        if (nmi && cur != 2) begin
            m_stk[m_cnt] = cur; m_cnt++; m_mode = 2;
        end else if (rt) begin
            if (cur != 0) begin
                if (m_cnt == 0) m_mode = 0;
                else begin m_cnt--; m_mode = m_stk[m_cnt]; end
            end
        end else if (irq && cur == 0) begin
            m_stk[m_cnt] = 0; m_cnt++; m_mode = 1;
        end
        exp_q.push_back({m_c[m_mode], m_z[m_mode], 2'(m_mode)});
        tag_q.push_back(tag);
    endtask

    // monitor: compares one queued item after each edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
        end
    end

    initial begin
        #100000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_mode = 2; m_cnt = 0;
        for (int i = 0; i < 3; i++) begin m_c[i] = 0; m_z[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare(4'b00_10, "R1 reset state");
        rst_n = 1'b1;
        @(negedge clk);
        compare(4'b00_10, "R1 after release");

        //   ac az bv cwe sel zwe irq nmi rt
        step(1, 0, 0, 1, 0, 0, 0, 0, 0, "R2 alu carry in nmi ctx");
        step(0, 1, 0, 0, 0, 1, 0, 0, 0, "R4 zero in nmi ctx");
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 irq ignored in nmi");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6 nmi ignored in nmi");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 reti empty record to main");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R8 reti in main");
        step(0, 0, 1, 1, 1, 0, 0, 0, 0, "R3 bit test into carry");
        step(0, 1, 1, 1, 0, 1, 1, 0, 0, "R10 write on irq entry");
        step(1, 1, 0, 1, 0, 1, 0, 0, 0, "R2 R4 irq ctx write");
        step(0, 0, 0, 0, 0, 0, 0, 1, 0, "R6 nmi from irq");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 unwind to irq");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R9 unwind to main keeps flags");
        step(0, 0, 0, 0, 0, 0, 1, 1, 0, "R11 nmi over irq");
        step(1, 0, 0, 0, 0, 0, 0, 0, 1, "R9 back to main");
        step(0, 0, 0, 0, 0, 0, 1, 0, 1, "R11 reti blocks irq");
        step(0, 0, 0, 0, 0, 0, 1, 0, 0, "R5 irq from main");
        step(0, 0, 0, 0, 0, 0, 0, 1, 1, "R11 nmi over reti");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 nested unwind");
        step(0, 0, 0, 0, 0, 0, 0, 0, 1, "R7 nested unwind to main");

        for (int n = 0; n < 400; n++) begin
            int r;
            r = $urandom_range(0, 99);
            step(1'($urandom), 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom),
                 r < 12, r >= 12 && r < 20, r >= 85, "R9 random mix");
        end
        step(0, 0, 0, 0, 0, 0, 0, 0, 0, "R9 idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule